// File: doc/BRIEF.md
# Hypercube Broadcast Stage Scheduler

This block sits in every node of a machine whose nodes form a hypercube of 2^DIM members, each with a DIM-bit address and direct links only to the DIM nodes whose address differs from its own in one bit. It sequences this node's part in a one-to-all broadcast that spreads along a binary tree. The set of nodes that hold the data doubles in every stage, so the whole machine is covered after DIM stages. In any stage a node sends no more than one message.

Every address is taken relative to the broadcast origin: the origin address is XORed with the node's own address. The origin holds the data from the start. A node whose relative address has its highest set bit at position k receives the data in stage k. In every later stage s it forwards the data across dimension s to the neighbour whose address differs from its own in bit s. The block raises a send request and the destination address for each stage. Surrounding logic moves the payload and pulses a stage strobe when a stage is over.

The controller is a three-state machine. IDLE is entered at reset. An accepted start pulse (the IDLE->RUN transition) moves it to RUN. RUN stays put until the stage strobe arrives in the last stage (the RUN->DONE transition). DONE then holds until the next start pulse (the DONE->RUN transition). No other transitions exist.

Top module: `hcube_bcast_sched`

## Requirements
- R1: After reset the block is in IDLE: busy, done, send_en, has_data and err are all 0, and stage_idx is 0.
- R2: A start pulse seen in IDLE or DONE makes busy 1 on the next cycle, with stage_idx 0, done 0 and err 0. On that same cycle has_data is 1 exactly when node_addr equals root_addr.
- R3: In RUN, each stage_tick adds one to stage_idx. A stage_tick seen while stage_idx is DIM-1 moves the block to DONE on the next cycle (busy 0, done 1), so a broadcast lasts exactly DIM strobes.
- R4: In stage s, send_en is 1 exactly when busy is 1, has_data is 1, and bits s and above of the relative address (node_addr XOR root_addr) are all zero.
- R5: While send_en is 1, send_dst equals node_addr with bit s inverted, so it differs from node_addr in exactly one bit.
- R6: On a non-origin node, an rx_valid in the stage whose number is the index of the highest set bit of the relative address sets has_data on the next cycle.
- R7: An rx_valid during RUN in any other stage, or on the origin node, sets err and leaves has_data unchanged. err then stays 1 until the next accepted start.
- R8: A start pulse while busy is ignored: stage_idx, has_data and busy are unchanged.
- R9: In DONE, done stays 1 and stage_tick has no effect until the next start pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| node_addr | input | DIM | Address of this node |
| root_addr | input | DIM | Address of the broadcast origin |
| start | input | 1 | Begin a broadcast (one-cycle pulse) |
| stage_tick | input | 1 | Marks the end of the current stage |
| rx_valid | input | 1 | Broadcast data arrived at this node |
| send_en | output | 1 | This node sends in the current stage |
| send_dst | output | DIM | Neighbour address for the send |
| stage_idx | output | $clog2(DIM) | Current stage number |
| has_data | output | 1 | This node holds the broadcast data |
| busy | output | 1 | State RUN |
| done | output | 1 | State DONE, all stages finished |
| err | output | 1 | Sticky flag for an unexpected receive |

## Verification
The assertions assume that node_addr and root_addr stay constant for the whole of a broadcast, and that start and stage_tick are clean pulses that are sampled on the clock. The bench sets both addresses only in the cycle that carries the accepted start, and it changes every input on the falling edge. Each pass through the stages checks several origin and node pairs, including the origin itself and receivers in the first, middle and last stage. Separate passes inject a receive in the wrong stage and a start pulse in the middle of a broadcast.

// File: rtl/hcube_bcast_pkg.sv
package hcube_bcast_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } bc_state_t;
endpackage

// File: rtl/hcube_stage_ctr.sv
module hcube_stage_ctr #(
    parameter int DIM = 3,
    localparam int SW = (DIM > 1) ? $clog2(DIM) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          adv,
    output logic [SW-1:0] stage,
    output logic          last
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            stage <= '0;
        else if (clear)
            stage <= '0;
        else if (adv && !last)
            stage <= stage + SW'(1);
    end

    assign last = (stage == SW'(DIM - 1));
endmodule

// File: rtl/hcube_route.sv
module hcube_route #(
    parameter int DIM = 3,
    localparam int SW = (DIM > 1) ? $clog2(DIM) : 1
) (
    input  logic [DIM-1:0] node,
    input  logic [DIM-1:0] root,
    input  logic [SW-1:0]  stage,
    output logic           is_root,
    output logic [SW-1:0]  rx_stage,
    output logic           upper_clear,
    output logic [DIM-1:0] dst
);
    logic [DIM-1:0] rel;

    assign rel     = node ^ root;
    assign is_root = (rel == '0);

    // index of the highest set bit of the relative address
    always_comb begin
        rx_stage = '0;
        for (int i = 0; i < DIM; i++)
            if (rel[i]) rx_stage = SW'(i);
    end

    assign upper_clear = ((rel >> stage) == '0);
    assign dst         = node ^ (DIM'(1) << stage);
endmodule

// File: rtl/hcube_bcast_sched.sv
module hcube_bcast_sched
    import hcube_bcast_pkg::*;
#(
    parameter int DIM = 3,
    localparam int SW = (DIM > 1) ? $clog2(DIM) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [DIM-1:0] node_addr,
    input  logic [DIM-1:0] root_addr,
    input  logic           start,
    input  logic           stage_tick,
    input  logic           rx_valid,
    output logic           send_en,
    output logic [DIM-1:0] send_dst,
    output logic [SW-1:0]  stage_idx,
    output logic           has_data,
    output logic           busy,
    output logic           done,
    output logic           err
);
    bc_state_t state_q, state_d;

    logic          is_root;
    logic [SW-1:0] rx_stage;
    logic          upper_clear;
    logic          last;
    logic          start_ok;
    logic          in_run;
    logic          rx_match;

    assign in_run   = (state_q == ST_RUN);
    assign start_ok = start && !in_run;
    assign rx_match = !is_root && (stage_idx == rx_stage);

    hcube_stage_ctr #(.DIM(DIM)) u_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (start_ok),
        .adv   (in_run && stage_tick),
        .stage (stage_idx),
        .last  (last)
    );

    hcube_route #(.DIM(DIM)) u_route (
        .node        (node_addr),
        .root        (root_addr),
        .stage       (stage_idx),
        .is_root     (is_root),
        .rx_stage    (rx_stage),
        .upper_clear (upper_clear),
        .dst         (send_dst)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start)              state_d = ST_RUN;
            ST_RUN:  if (stage_tick && last) state_d = ST_DONE;
            ST_DONE: if (start)              state_d = ST_RUN;
            default:                         state_d = ST_IDLE;
        endcase
    end

    // holding flag and sticky error
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            has_data <= 1'b0;
            err      <= 1'b0;
        end else if (start_ok) begin
            has_data <= is_root;
            err      <= 1'b0;
        end else if (in_run && rx_valid) begin
            if (rx_match) has_data <= 1'b1;
            else          err      <= 1'b1;
        end
    end

    // outputs
    always_comb begin
        busy    = 1'b0;
        done    = 1'b0;
        send_en = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_RUN: begin
                busy    = 1'b1;
                send_en = has_data && upper_clear;
            end
            ST_DONE: done = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/hcube_bcast_sched_chk.sv
module hcube_bcast_sched_chk #(
    parameter int DIM = 3,
    localparam int SW = (DIM > 1) ? $clog2(DIM) : 1
) (
    input logic           clk,
    input logic           rst_n,
    input logic [DIM-1:0] node_addr,
    input logic           start,
    input logic           stage_tick,
    input logic           send_en,
    input logic [DIM-1:0] send_dst,
    input logic [SW-1:0]  stage_idx,
    input logic           has_data,
    input logic           busy,
    input logic           done,
    input logic           err
);
    assert_start_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (busy && stage_idx == '0 && !err && !done));

    assert_stage_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && stage_tick && stage_idx != SW'(DIM - 1)) |=>
        (busy && stage_idx == $past(stage_idx) + SW'(1)));

    assert_finish_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && stage_tick && stage_idx == SW'(DIM - 1)) |=> (done && !busy));

    assert_send_holder_R4: assert property (@(posedge clk) disable iff (!rst_n)
        send_en |-> (busy && has_data));

    assert_one_bit_dst_R5: assert property (@(posedge clk) disable iff (!rst_n)
        send_en |-> ($countones(send_dst ^ node_addr) == 1));

    assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (err && !start) |=> err);

    assert_start_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && !stage_tick) |=> (busy && $stable(stage_idx)));

    assert_done_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> done);

    assert_state_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));
endmodule

bind hcube_bcast_sched hcube_bcast_sched_chk #(.DIM(DIM)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .node_addr  (node_addr),
    .start      (start),
    .stage_tick (stage_tick),
    .send_en    (send_en),
    .send_dst   (send_dst),
    .stage_idx  (stage_idx),
    .has_data   (has_data),
    .busy       (busy),
    .done       (done),
    .err        (err)
);

// File: tb/hcube_bcast_sched_bench.sv
module hcube_bcast_sched_bench;
    localparam int DIM = 3;
    localparam int SW  = 2;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [DIM-1:0] node_addr = '0;
    logic [DIM-1:0] root_addr = '0;
    logic           start = 1'b0;
    logic           stage_tick = 1'b0;
    logic           rx_valid = 1'b0;
    logic           send_en;
    logic [DIM-1:0] send_dst;
    logic [SW-1:0]  stage_idx;
    logic           has_data;
    logic           busy;
    logic           done;
    logic           err;

    int n_chk  = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    typedef struct packed {
        logic [SW-1:0]  stg;
        logic           snd;
        logic [DIM-1:0] dst;
        logic           hold;
    } exp_t;

    exp_t exp_q[$];
    event chk_ev;

    always #10ns clk = ~clk;

    hcube_bcast_sched #(.DIM(DIM)) u_hcube_bcast_sched (
        .clk(clk), .rst_n(rst_n), .node_addr(node_addr), .root_addr(root_addr),
        .start(start), .stage_tick(stage_tick), .rx_valid(rx_valid),
        .send_en(send_en), .send_dst(send_dst), .stage_idx(stage_idx),
        .has_data(has_data), .busy(busy), .done(done), .err(err)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // monitor: pops one expected stage record per event and compares
    initial begin
        forever begin
            @(chk_ev);
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                check("R3 stage", int'(stage_idx), int'(e.stg));
                check("R6 has_data", int'(has_data), int'(e.hold));
                check("R4 send_en", int'(send_en), int'(e.snd));
                if (e.snd) check("R5 send_dst", int'(send_dst), int'(e.dst));
            end
        end
    end

    function automatic int top_bit(input logic [DIM-1:0] r);
        int k = 0;
        for (int i = 0; i < DIM; i++) if (r[i]) k = i;
        return k;
    endfunction

    // bad_stg: stage in which to inject a misplaced receive (-1: none)
    // mid_start: pulse start at stage 1 before its strobe
    task automatic run_bcast(input logic [DIM-1:0] nd, input logic [DIM-1:0] rt,
                             input int bad_stg, input bit mid_start);
        logic [DIM-1:0] rel;
        logic hold;
        bit exp_err;
        int rs;
        rel = nd ^ rt;
        rs = top_bit(rel);
        hold = (rel == '0);
        exp_err = 1'b0;
        @(negedge clk);
        node_addr = nd; root_addr = rt; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R2 busy", int'(busy), 1);
        check("R2 done", int'(done), 0);
        check("R2 err", int'(err), 0);
        check("R2 has_data", int'(has_data), int'(hold));
        for (int s = 0; s < DIM; s++) begin
            exp_t e;
            if (mid_start && s == 1) begin
                start = 1'b1;
                @(negedge clk);
                start = 1'b0;
                check("R8 busy", int'(busy), 1);
                check("R8 stage", int'(stage_idx), 1);
                check("R8 has_data", int'(has_data), int'(hold));
            end
            e.stg  = SW'(s);
            e.hold = hold;
            e.snd  = hold && ((rel >> s) == '0);
            e.dst  = nd ^ (DIM'(1) << s);
            exp_q.push_back(e);
            -> chk_ev;
            #1ns;
            if (s == bad_stg) begin
                rx_valid = 1'b1;
                exp_err = 1'b1;
            end else if (rel != '0 && s == rs) begin
                rx_valid = 1'b1;
                hold = 1'b1;
            end
            stage_tick = 1'b1;
            @(negedge clk);
            rx_valid = 1'b0;
            stage_tick = 1'b0;
            if (s == bad_stg) check("R7 err", int'(err), 1);
        end
        check("R3 done", int'(done), 1);
        check("R3 busy", int'(busy), 0);
        check("R7 err after run", int'(err), int'(exp_err));
        check("R6 final has_data", int'(has_data), int'(hold));
    endtask

    initial begin
        #(20ns * 100000);
        if (!finished) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 busy", int'(busy), 0);
        check("R1 done", int'(done), 0);
        check("R1 send_en", int'(send_en), 0);
        check("R1 has_data", int'(has_data), 0);
        check("R1 err", int'(err), 0);
        check("R1 stage", int'(stage_idx), 0);
        rst_n = 1'b1;

        run_bcast(3'd5, 3'd5, -1, 1'b0);   // origin sends every stage
        run_bcast(3'd6, 3'd2, -1, 1'b0);   // receives in last stage
        run_bcast(3'd3, 3'd0, -1, 1'b0);   // receives in middle stage
        run_bcast(3'd1, 3'd0, -1, 1'b0);   // receives in first stage
        run_bcast(3'd7, 3'd1, -1, 1'b1);   // start mid-run ignored (R8)

        // R9: done holds, strobes ignored
        @(negedge clk);
        stage_tick = 1'b1;
        repeat (2) @(negedge clk);
        stage_tick = 1'b0;
        check("R9 done held", int'(done), 1);
        check("R9 stage held", int'(stage_idx), DIM - 1);

        run_bcast(3'd3, 3'd0, 0, 1'b0);    // R7: receive too early
        run_bcast(3'd4, 3'd4, 2, 1'b0);    // R7: origin receives
        run_bcast(3'd2, 3'd0, -1, 1'b0);   // R2: err cleared by start

        repeat (2) @(negedge clk);
        check("R3 scoreboard drained", exp_q.size(), 0);
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule